// File: doc/BRIEF.md
# Memory Array Integrity Sweep Controller

This block checks a memory array by reading it end to end and compressing every word it reads into a 32-bit multiple-input signature register (MISR). Software writes a start bit. The block then reads each word of every block that is both selected and not locked, in ascending address order. It folds each returned word into the signature. When the last word has been folded, it raises a done flag. Software then reads the signature and compares it with a value computed offline.

The block has a small register port with four word offsets:
- Offset 0 is control and status.
- Offset 1 is a 32-bit test word. It supplies data-injection bits for the ECC check of the low half of a 64-bit double word, and it drives `ecc_inject`.
- Offset 2 is the signature.
- Offset 3 reads as zero.

The block will not start while the erase, program or high-voltage controls are active. In margin mode it only accepts a start that asks for sequential order. The array side is a request port with a fixed one-cycle read latency and no back-pressure. The block issues one request per cycle while it runs, and the array must return the data on the following cycle without stalling.

Top module: `integrity_sweep`

## Requirements
- R1: After reset, `chk_done` is 1 and `arr_rd_en` is 0. Offset 0 reads 0x4. Offset 1 and offset 2 read 0, and `ecc_inject` is 0.
- R2: A write to offset 0 with bit 0 set starts a sweep when all of these hold: the block is idle, `ctrl_erase`, `ctrl_prog` and `ctrl_hv` are all 0, and the margin rule of R4 allows it. `chk_done` is 0 from the next cycle, and the signature is reseeded to 0. Offset 0 layout is: bit 0 = running (read-only), bit 1 = sequential-order select (read/write), bit 2 = done (read-only).
- R3: A start write made while any of `ctrl_erase`, `ctrl_prog` or `ctrl_hv` is 1 is ignored. `chk_done` stays 1 and no read is issued.
- R4: While `margin_mode` is 1, a start write with bit 1 = 0 is rejected. A start write with bit 1 = 1 is accepted.
- R5: While a sweep runs, exactly one read is issued per cycle. The read address is {block index, word index}, with the block index in the upper bits. Addresses ascend strictly. Only blocks with `blk_sel`=1 and `blk_lock`=0, sampled at the start, are visited, and each of their words is read exactly once.
- R6: Each returned word d updates the signature s to (s<<1) ^ (s[31] ? 0x00400007 : 0) ^ d. This is the polynomial x^32+x^22+x^2+x+1. The returned word is the array data on the cycle after its request.
- R7: `chk_done` returns to 1 exactly N*W+1 cycles after the start edge, where N is the number of eligible blocks and W is the number of words per block. At that point offset 2 holds the final signature.
- R8: With no eligible block, `chk_done` returns to 1 one cycle after the start edge, and the signature reads 0.
- R9: Writes to offset 0 while a sweep runs are ignored. The sweep neither restarts nor changes its blocks or timing, and bit 1 keeps its value.
- R10: Offset 1 can be written and read only while both `ctrl_done` and `chk_done` are 1. At other times a write has no effect, and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| ctrl_erase | input | 1 | Erase operation active |
| ctrl_prog | input | 1 | Program operation active |
| ctrl_hv | input | 1 | High-voltage enable active |
| ctrl_done | input | 1 | Global operation-done status |
| margin_mode | input | 1 | Margin read mode active |
| blk_sel | input | NUM_BLK | Per-block select |
| blk_lock | input | NUM_BLK | Per-block lock |
| arr_rd_en | output | 1 | Array read request |
| arr_rd_addr | output | BLK_W+WORD_W | Array word address {block, word} |
| arr_rd_data | input | 32 | Array read data, valid one cycle after the request |
| ecc_inject | output | 32 | Test word for the ECC check of the low 32 bits |
| chk_done | output | 1 | Integrity sweep done flag |

## Verification
The assertions assume the register strobe and the status inputs are steady for a whole cycle around each rising edge. They also assume the array answers every request on the next cycle with no stall. The bench meets this by changing its inputs only on falling edges. Its array model registers data on the rising edge after each request.

The sweep assertions assume `blk_sel` and `blk_lock` only matter at the start edge. The bench deliberately changes them in the middle of a sweep, so that the latching of the block mask is visible in the signature and in the sweep's duration.

// File: rtl/isw_pkg.sv
package isw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } sweep_st_e;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_INJ  = 2'd1;
  localparam logic [1:0] OFS_SIG  = 2'd2;

  localparam int CB_RUN  = 0;
  localparam int CB_SEQ  = 1;
  localparam int CB_DONE = 2;

  localparam int          SIG_W    = 32;
  localparam logic [31:0] SIG_POLY = 32'h0040_0007;
endpackage

// File: rtl/isw_blk_pick.sv
module isw_blk_pick #(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3
) (
  input  logic [NUM_BLK-1:0] mask,
  input  logic [BLK_W:0]     from,
  output logic               found,
  output logic [BLK_W-1:0]   idx
);
  logic [NUM_BLK-1:0] qual;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_qual
    assign qual[g] = mask[g] && ((BLK_W+1)'(g) >= from);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_BLK - 1; i >= 0; i--) begin
      if (qual[i]) begin
        found = 1'b1;
        idx   = BLK_W'(i);
      end
    end
  end
endmodule

// File: rtl/isw_misr.sv
module isw_misr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = 32'h0040_0007
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed,
  input  logic         fold,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = {sig[W-2:0], 1'b0} ^ din;
    if (sig[W-1]) nxt = nxt ^ POLY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sig <= '0;
    else if (seed) sig <= '0;
    else if (fold) sig <= nxt;
  end
endmodule

// File: rtl/isw_sequencer.sv
module isw_sequencer
  import isw_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int BLK_W   = 3,
  parameter int WORD_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NUM_BLK-1:0]      mask_in,
  output logic                    rd_en,
  output logic [BLK_W+WORD_W-1:0] rd_addr,
  output logic                    fold,
  output logic                    done,
  output logic                    busy
);
  localparam logic [WORD_W-1:0] LAST_WORD = '1;

  sweep_st_e          state;
  logic [NUM_BLK-1:0] mask_q;
  logic [BLK_W-1:0]   cur_blk;
  logic [WORD_W-1:0]  cur_word;
  logic               vld_q;

  logic [NUM_BLK-1:0] pick_mask;
  logic [BLK_W:0]     pick_from;
  logic               pick_found;
  logic [BLK_W-1:0]   pick_idx;

  always_comb begin
    if (state == ST_IDLE) begin
      pick_mask = mask_in;
      pick_from = '0;
    end else begin
      pick_mask = mask_q;
      pick_from = {1'b0, cur_blk} + (BLK_W+1)'(1);
    end
  end

  isw_blk_pick #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) pick_i (
    .mask  (pick_mask),
    .from  (pick_from),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mask_q   <= '0;
      cur_blk  <= '0;
      cur_word <= '0;
      vld_q    <= 1'b0;
      done     <= 1'b1;
    end else begin
      vld_q <= (state == ST_SCAN);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mask_q   <= mask_in;
            done     <= 1'b0;
            cur_word <= '0;
            if (pick_found) begin
              cur_blk <= pick_idx;
              state   <= ST_SCAN;
            end else begin
              state   <= ST_DRAIN;
            end
          end
        end
        ST_SCAN: begin
          if (cur_word == LAST_WORD) begin
            cur_word <= '0;
            if (pick_found) cur_blk <= pick_idx;
            else            state   <= ST_DRAIN;
          end else begin
            cur_word <= cur_word + WORD_W'(1);
          end
        end
        ST_DRAIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_en   = (state == ST_SCAN);
  assign rd_addr = {cur_blk, cur_word};
  assign fold    = vld_q;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/isw_regs.sv
module isw_regs
  import isw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ctrl_erase,
  input  logic             ctrl_prog,
  input  logic             ctrl_hv,
  input  logic             ctrl_done,
  input  logic             margin_mode,
  input  logic             done,
  input  logic             busy,
  input  logic [SIG_W-1:0] sig,
  output logic             start,
  output logic [31:0]      ecc_inject
);
  logic seq_q;
  logic ctrl_wr;
  logic interlock;
  logic order_bad;
  logic inj_open;

  assign ctrl_wr   = reg_wr && (reg_addr == OFS_CTRL) && !busy;
  assign interlock = ctrl_erase || ctrl_prog || ctrl_hv;
  assign order_bad = margin_mode && !reg_wdata[CB_SEQ];
  assign start     = ctrl_wr && reg_wdata[CB_RUN] && !interlock && !order_bad;
  assign inj_open  = ctrl_done && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= 1'b0;
      ecc_inject <= '0;
    end else begin
      if (ctrl_wr) seq_q <= reg_wdata[CB_SEQ];
      if (reg_wr && (reg_addr == OFS_INJ) && inj_open) ecc_inject <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CB_RUN]  = busy;
        reg_rdata[CB_SEQ]  = seq_q;
        reg_rdata[CB_DONE] = done;
      end
      OFS_INJ: reg_rdata = inj_open ? ecc_inject : '0;
      OFS_SIG: reg_rdata = sig;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/integrity_sweep.sv
module integrity_sweep
  import isw_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int WORD_W  = 4,
  localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int ADDR_W = BLK_W + WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               ctrl_erase,
  input  logic               ctrl_prog,
  input  logic               ctrl_hv,
  input  logic               ctrl_done,
  input  logic               margin_mode,
  input  logic [NUM_BLK-1:0] blk_sel,
  input  logic [NUM_BLK-1:0] blk_lock,
  output logic               arr_rd_en,
  output logic [ADDR_W-1:0]  arr_rd_addr,
  input  logic [31:0]        arr_rd_data,
  output logic [31:0]        ecc_inject,
  output logic               chk_done
);
  logic             start;
  logic             busy;
  logic             fold;
  logic [SIG_W-1:0] sig;

  isw_regs regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ctrl_erase  (ctrl_erase),
    .ctrl_prog   (ctrl_prog),
    .ctrl_hv     (ctrl_hv),
    .ctrl_done   (ctrl_done),
    .margin_mode (margin_mode),
    .done        (chk_done),
    .busy        (busy),
    .sig         (sig),
    .start       (start),
    .ecc_inject  (ecc_inject)
  );

  isw_sequencer #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .WORD_W(WORD_W)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mask_in (blk_sel & ~blk_lock),
    .rd_en   (arr_rd_en),
    .rd_addr (arr_rd_addr),
    .fold    (fold),
    .done    (chk_done),
    .busy    (busy)
  );

  isw_misr #(.W(SIG_W), .POLY(SIG_POLY)) misr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .seed  (start),
    .fold  (fold),
    .din   (arr_rd_data),
    .sig   (sig)
  );
endmodule

// File: rtl/isw_checker.sv
module isw_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [1:0]        wbits,
  input logic              ctrl_erase,
  input logic              ctrl_prog,
  input logic              ctrl_hv,
  input logic              ctrl_done,
  input logic              margin_mode,
  input logic              arr_rd_en,
  input logic [ADDR_W-1:0] arr_rd_addr,
  input logic [31:0]       ecc_inject,
  input logic              chk_done
);
  logic start_wr;
  logic locked_out;
  assign start_wr   = reg_wr && (reg_addr == 2'd0) && wbits[0] && chk_done;
  assign locked_out = ctrl_erase || ctrl_prog || ctrl_hv;

  // R2
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !locked_out && !(margin_mode && !wbits[1])) |=> !chk_done);

  // R3
  interlock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && locked_out) |=> (chk_done && !arr_rd_en));

  // R4
  margin_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && margin_mode && !wbits[1]) |=> chk_done);

  // R5
  addr_ascends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd_en && $past(arr_rd_en)) |-> (arr_rd_addr > $past(arr_rd_addr)));

  // R7
  reads_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |-> !chk_done);

  // R10
  inject_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_done && chk_done) |=> $stable(ecc_inject));
endmodule

bind integrity_sweep isw_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .wbits       (reg_wdata[1:0]),
  .ctrl_erase  (ctrl_erase),
  .ctrl_prog   (ctrl_prog),
  .ctrl_hv     (ctrl_hv),
  .ctrl_done   (ctrl_done),
  .margin_mode (margin_mode),
  .arr_rd_en   (arr_rd_en),
  .arr_rd_addr (arr_rd_addr),
  .ecc_inject  (ecc_inject),
  .chk_done    (chk_done)
);

// File: tb/integrity_sweep_tb_top.sv
module integrity_sweep_tb_top;
  localparam int NB = 4;
  localparam int WW = 2;
  localparam int NW = 1 << WW;
  localparam int AW = 2 + WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          ctrl_erase = 1'b0, ctrl_prog = 1'b0, ctrl_hv = 1'b0;
  logic          ctrl_done = 1'b1, margin_mode = 1'b0;
  logic [NB-1:0] blk_sel = '0, blk_lock = '0;
  logic          arr_rd_en;
  logic [AW-1:0] arr_rd_addr;
  logic [31:0]   arr_rd_data = '0;
  logic [31:0]   ecc_inject;
  logic          chk_done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int log_n = 0;
  logic [AW-1:0] addr_log [0:63];

  always #10 clk = ~clk;

  integrity_sweep #(.NUM_BLK(NB), .WORD_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_erase(ctrl_erase),
    .ctrl_prog(ctrl_prog), .ctrl_hv(ctrl_hv), .ctrl_done(ctrl_done),
    .margin_mode(margin_mode), .blk_sel(blk_sel), .blk_lock(blk_lock),
    .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
    .ecc_inject(ecc_inject), .chk_done(chk_done)
  );

  function automatic logic [31:0] word_at(logic [AW-1:0] a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [31:0] exp_sig(logic [NB-1:0] m);
    logic [31:0] s = '0;
    for (int b = 0; b < NB; b++)
      if (m[b])
        for (int w = 0; w < NW; w++)
          s = {s[30:0], 1'b0} ^ (s[31] ? 32'h0040_0007 : 32'h0) ^ word_at(AW'(b * NW + w));
    return s;
  endfunction

  always @(posedge clk) if (arr_rd_en) arr_rd_data <= word_at(arr_rd_addr);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (arr_rd_en && log_n < 64) begin
      addr_log[log_n] <= arr_rd_addr;
      log_n <= log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!chk_done && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic sweep(input logic [NB-1:0] sel, input logic [NB-1:0] lock);
    logic [NB-1:0] m = sel & ~lock;
    int nb = $countones(m);
    int n, bad, k;
    logic [31:0] v;
    blk_sel = sel; blk_lock = lock;
    log_n = 0;
    wr(2'd0, 32'h3);
    check(!chk_done, "R2", "done low after start", 32'(chk_done), 0);
    wait_done(n);
    check(n == nb * NW + 1, (nb == 0) ? "R8" : "R7", "cycles to done", n, nb * NW + 1);
    bad = 0; k = 0;
    for (int b = 0; b < NB; b++)
      if (m[b])
        for (int w = 0; w < NW; w++) begin
          if (k >= log_n || addr_log[k] != AW'(b * NW + w)) bad++;
          k++;
        end
    check(bad == 0 && log_n == nb * NW, "R5", "read address sequence", log_n, nb * NW);
    rd(2'd2, v);
    check(v == exp_sig(m), (nb == 0) ? "R8" : "R6", "signature", v, exp_sig(m));
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(chk_done == 1'b1 && arr_rd_en == 1'b0, "R1", "done/read after reset",
          {30'b0, chk_done, arr_rd_en}, 32'h2);
    rd(2'd0, v); check(v == 32'h4, "R1", "ctrl reset", v, 32'h4);
    rd(2'd1, v); check(v == 0 && ecc_inject == 0, "R1", "inject reset", v, 0);
    rd(2'd2, v); check(v == 0, "R1", "signature reset", v, 0);

    // R10 test word access
    wr(2'd1, 32'hDEAD_BEEF);
    rd(2'd1, v); check(v == 32'hDEAD_BEEF, "R10", "inject readback", v, 32'hDEAD_BEEF);
    check(ecc_inject == 32'hDEAD_BEEF, "R10", "inject output", ecc_inject, 32'hDEAD_BEEF);
    ctrl_done = 1'b0;
    wr(2'd1, 32'h0000_0001);
    rd(2'd1, v); check(v == 0, "R10", "blocked read", v, 0);
    check(ecc_inject == 32'hDEAD_BEEF, "R10", "blocked write", ecc_inject, 32'hDEAD_BEEF);
    ctrl_done = 1'b1;

    // R5 R6 R7 R8 sweeps over all select masks and several lock masks
    for (int s = 0; s < 16; s++)
      for (int l = 0; l < 4; l++)
        sweep(NB'(s), NB'((l * 5) & 4'hF));

    // R3 interlocks
    for (int k = 0; k < 3; k++) begin
      blk_sel = '1; blk_lock = '0;
      ctrl_erase = (k == 0); ctrl_prog = (k == 1); ctrl_hv = (k == 2);
      log_n = 0;
      wr(2'd0, 32'h3);
      repeat (3) @(negedge clk);
      check(chk_done && log_n == 0, "R3", "start under interlock", log_n, 0);
    end
    ctrl_erase = 0; ctrl_prog = 0; ctrl_hv = 0;

    // R4 margin mode order rule
    margin_mode = 1'b1;
    log_n = 0;
    wr(2'd0, 32'h1);
    repeat (2) @(negedge clk);
    check(chk_done && log_n == 0, "R4", "non-sequential start rejected", log_n, 0);
    sweep(4'b0110, 4'b0000);
    check(log_n == 2 * NW, "R4", "sequential start accepted", log_n, 2 * NW);
    margin_mode = 1'b0;

    // R9 writes during a sweep
    blk_sel = 4'b1111; blk_lock = '0;
    wr(2'd0, 32'h3);
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    blk_sel = 4'b0001;
    wr(2'd0, 32'h1);
    n += 2;
    ctrl_done = 1'b1;
    wr(2'd1, 32'h1234_5678);
    n += 2;
    check(ecc_inject == 32'hDEAD_BEEF, "R10", "inject write while busy", ecc_inject, 32'hDEAD_BEEF);
    while (!chk_done && n < 1000) begin @(negedge clk); n++; end
    check(n == NB * NW + 1, "R9", "no restart timing", n, NB * NW + 1);
    rd(2'd2, v); check(v == exp_sig(4'hF), "R9", "signature unaffected", v, exp_sig(4'hF));
    rd(2'd0, v); check(v == 32'h6, "R9", "seq bit kept", v, 32'h6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule